// File: doc/BRIEF.md
# Descending Stack Sequencer

This block owns the stack pointer, frame pointer and instruction pointer of a 32-bit core. It carries out the stack-related commands: single push and pop, subroutine call and return, and the frame setup and teardown pair. It takes one command at a time. It breaks compound commands into a fixed order of pointer steps and single-word memory accesses on a word-addressed data port. When the last step is finished it pulses `done`.

The stack grows toward lower addresses in steps of one 32-bit word, which is 4 bytes. The pointers are byte addresses. The memory port carries the word index, which is the pointer shifted right by two. Each memory access holds its request until the memory acknowledges it, so the block works with any memory latency. Decoding instructions, computing call targets and detecting stack overflow are left to the surrounding logic. The address of the instruction after a call is supplied on its own input.

Top module: `stack_engine`

## Requirements
- R1: After reset `spOut`, `fpOut` and `ipOut` hold the parameters SP_RESET, FP_RESET and IP_RESET, and `busy`, `done` and `memReq` are low.
- R2: Command code 0 (push) first lowers the stack pointer by 4. It then writes `cmdArg` to the word at the new stack pointer. The memory word index is the byte pointer shifted right by 2.
- R3: Command code 1 (pop) reads the word at the current stack pointer onto `popData`, and after the read it raises the stack pointer by 4.
- R4: Command code 2 (call) lowers the stack pointer by 4, writes `retAddr` to the new top, and then loads `cmdArg` into the instruction pointer.
- R5: Command code 3 (return) reads the top word into the instruction pointer and then raises the stack pointer by 4.
- R6: Command code 4 (frame enter) pushes the current frame pointer and then copies the new stack pointer into the frame pointer.
- R7: Command code 5 (frame leave) copies the frame pointer into the stack pointer, then reads the word there into the frame pointer, and then raises the stack pointer by 4.
- R8: `busy` is high from the cycle after acceptance until the command ends. `done` is a one-cycle pulse at the end. While `busy` is low, `memReq` stays low and no pointer changes.
- R9: An access holds `memReq`, `memWe`, `memAddr` and `memWdata` unchanged until `memAck`, with no limit on the wait.
- R10: `cmdValid` seen while `busy` is high is ignored.
- R11: Command codes 6 and 7 complete with a `done` pulse and leave all pointers and memory unchanged.
- R12: A command changes no pointer outside its own description: push and pop keep the frame and instruction pointers, call and return keep the frame pointer, and frame enter and leave keep the instruction pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; taken only when idle |
| cmdOp | input | 3 | Command code |
| cmdArg | input | DW | Push data or call target |
| retAddr | input | DW | Address after the call instruction |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | DW | Stack pointer (byte address) |
| fpOut | output | DW | Frame pointer (byte address) |
| ipOut | output | DW | Instruction pointer |
| popData | output | DW | Word read by the last pop |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | DW-2 | Word index |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid with memAck |
| memAck | input | 1 | Access complete |

## Verification
The bench runs each command and varies the memory latency from zero to several cycles. A sequencer that leaves a state without waiting for the acknowledge would lose writes or capture stale read data. The bench also checks step order in the compound commands: a write before the decrement would overwrite the old top word, and a frame leave that pops before it restores the stack pointer would reload the frame pointer from the wrong word. A second command is raised while one is in progress, and unused codes are issued. A design that accepted either one would move the instruction or stack pointer when it should not.

// File: rtl/stack_engine_pkg.sv
package stack_engine_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_ENTER = 3'd4,
    OP_LEAVE = 3'd5
  } stackOp_e;

  typedef enum logic [1:0] {
    WSRC_ARG = 2'd0,
    WSRC_RET = 2'd1,
    WSRC_FP  = 2'd2
  } wrSrc_e;

  typedef enum logic [1:0] {
    RDST_POP = 2'd0,
    RDST_IP  = 2'd1,
    RDST_FP  = 2'd2
  } rdDest_e;

  typedef struct packed {
    logic    latch;
    logic    spDec;
    logic    spInc;
    logic    spLoadFp;
    logic    fpLoadSp;
    logic    ipLoadArg;
    logic    rdCapture;
    rdDest_e rdDest;
    wrSrc_e  wrSrc;
  } strobes_t;

endpackage

// File: rtl/stack_engine_ctrl.sv
module stack_engine_ctrl
  import stack_engine_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       memAck,
  output logic       busy,
  output logic       done,
  output logic       memReq,
  output logic       memWe,
  output strobes_t   strobes
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_WRITE, S_READ, S_INC, S_SPFP, S_FPSP, S_SETIP, S_FIN
  } state_e;

  state_e     state, stateNext;
  logic [2:0] opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= 3'd0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && cmdValid) opReg <= cmdOp;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (cmdOp)
            OP_PUSH, OP_CALL, OP_ENTER: stateNext = S_DEC;
            OP_POP, OP_RET:             stateNext = S_READ;
            OP_LEAVE:                   stateNext = S_SPFP;
            default:                    stateNext = S_FIN;
          endcase
        end
      end
      S_DEC:   stateNext = S_WRITE;
      S_WRITE: begin
        if (memAck) begin
          case (opReg)
            OP_CALL:  stateNext = S_SETIP;
            OP_ENTER: stateNext = S_FPSP;
            default:  stateNext = S_FIN;
          endcase
        end
      end
      S_READ:  if (memAck) stateNext = S_INC;
      S_SPFP:  stateNext = S_READ;
      S_INC, S_FPSP, S_SETIP: stateNext = S_FIN;
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.latch     = (state == S_IDLE) && cmdValid;
    strobes.spDec     = (state == S_DEC);
    strobes.spInc     = (state == S_INC);
    strobes.spLoadFp  = (state == S_SPFP);
    strobes.fpLoadSp  = (state == S_FPSP);
    strobes.ipLoadArg = (state == S_SETIP);
    strobes.rdCapture = (state == S_READ) && memAck;
    case (opReg)
      OP_RET:   strobes.rdDest = RDST_IP;
      OP_LEAVE: strobes.rdDest = RDST_FP;
      default:  strobes.rdDest = RDST_POP;
    endcase
    case (opReg)
      OP_CALL:  strobes.wrSrc = WSRC_RET;
      OP_ENTER: strobes.wrSrc = WSRC_FP;
      default:  strobes.wrSrc = WSRC_ARG;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign memReq = (state == S_WRITE) || (state == S_READ);
  assign memWe  = (state == S_WRITE);

endmodule

// File: rtl/stack_engine_dp.sv
module stack_engine_dp
  import stack_engine_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] SP_RESET = '0,
  parameter logic [DW-1:0] FP_RESET = '0,
  parameter logic [DW-1:0] IP_RESET = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strobes,
  input  logic [DW-1:0] cmdArg,
  input  logic [DW-1:0] retAddr,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] fpOut,
  output logic [DW-1:0] ipOut,
  output logic [DW-1:0] popData,
  output logic [DW-3:0] memAddr,
  output logic [DW-1:0] memWdata
);

  localparam int          AW       = DW - 2;
  localparam logic [DW-1:0] WORD_BYTES = DW'(4);

  logic [DW-1:0] spReg, fpReg, ipReg, popReg, argReg, retReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg  <= SP_RESET;
      fpReg  <= FP_RESET;
      ipReg  <= IP_RESET;
      popReg <= '0;
      argReg <= '0;
      retReg <= '0;
    end else begin
      if (strobes.latch) begin
        argReg <= cmdArg;
        retReg <= retAddr;
      end
      if (strobes.spDec)         spReg <= spReg - WORD_BYTES;
      else if (strobes.spInc)    spReg <= spReg + WORD_BYTES;
      else if (strobes.spLoadFp) spReg <= fpReg;
      if (strobes.fpLoadSp) fpReg <= spReg;
      if (strobes.ipLoadArg) ipReg <= argReg;
      if (strobes.rdCapture) begin
        case (strobes.rdDest)
          RDST_IP:  ipReg  <= memRdata;
          RDST_FP:  fpReg  <= memRdata;
          default:  popReg <= memRdata;
        endcase
      end
    end
  end

  always_comb begin
    case (strobes.wrSrc)
      WSRC_RET: memWdata = retReg;
      WSRC_FP:  memWdata = fpReg;
      default:  memWdata = argReg;
    endcase
  end

  assign memAddr = spReg[DW-1:DW-AW];
  assign spOut   = spReg;
  assign fpOut   = fpReg;
  assign ipOut   = ipReg;
  assign popData = popReg;

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stack_engine_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] SP_RESET = DW'(32'h0000_0F00),
  parameter logic [DW-1:0] FP_RESET = DW'(32'h0000_0F00),
  parameter logic [DW-1:0] IP_RESET = DW'(32'h0000_1000)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [DW-1:0] cmdArg,
  input  logic [DW-1:0] retAddr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] fpOut,
  output logic [DW-1:0] ipOut,
  output logic [DW-1:0] popData,
  output logic          memReq,
  output logic          memWe,
  output logic [DW-3:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memAck
);

  strobes_t strobes;

  stack_engine_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .memAck(memAck), .busy(busy), .done(done),
    .memReq(memReq), .memWe(memWe), .strobes(strobes)
  );

  stack_engine_dp #(
    .DW(DW), .SP_RESET(SP_RESET), .FP_RESET(FP_RESET), .IP_RESET(IP_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdArg(cmdArg),
    .retAddr(retAddr), .memRdata(memRdata), .spOut(spOut), .fpOut(fpOut),
    .ipOut(ipOut), .popData(popData), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] spOut,
  input logic [DW-1:0] fpOut,
  input logic [DW-1:0] ipOut,
  input logic          memReq,
  input logic          memWe,
  input logic [DW-3:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memAck
);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)
                             && $stable(memWdata)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_idle_no_mem_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  assert_idle_regs_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(spOut) && $stable(fpOut) && $stable(ipOut)));

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

bind stack_engine stack_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .spOut(spOut),
  .fpOut(fpOut), .ipOut(ipOut), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/stack_engine_tb.sv
module stack_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam logic [31:0] SP0 = 32'h0000_0F00;
  localparam logic [31:0] FP0 = 32'h0000_0F00;
  localparam logic [31:0] IP0 = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [31:0] cmdArg = '0, retAddr = '0;
  logic busy, done, memReq, memWe, memAck;
  logic [31:0] spOut, fpOut, ipOut, popData, memWdata, memRdata;
  logic [29:0] memAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_engine #(.DW(DW), .SP_RESET(SP0), .FP_RESET(FP0), .IP_RESET(IP0)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .retAddr(retAddr), .busy(busy), .done(done),
    .spOut(spOut), .fpOut(fpOut), .ipOut(ipOut), .popData(popData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] refMem [0:1023];
  logic [31:0] refSp, refFp, refIp;
  int memLat = 0;
  int latCnt = 0;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  initial begin
    memAck = 1'b0;
    memRdata = '0;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA500_0000 + 32'(i * 3);
      refMem[i] = 32'hA500_0000 + 32'(i * 3);
    end
  end

  always @(negedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (latCnt >= memLat) begin
        memAck <= 1'b1;
        memRdata <= mem[memAddr[9:0]];
        if (memWe) mem[memAddr[9:0]] <= memWdata;
        latCnt = 0;
      end else begin
        latCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [31:0] arg, input logic [31:0] ra);
    int waitCnt;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; retAddr = ra;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R8 busy after accept", {31'b0, busy}, 32'd1);
    waitCnt = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    check("R8 done seen", {31'b0, done}, 32'd1);
    @(negedge clk);
    check("R8 done one cycle", {31'b0, done}, 32'd0);
    check("R8 idle after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " sp"}, spOut, refSp);
    check({tag, " fp"}, fpOut, refFp);
    check({tag, " ip"}, ipOut, refIp);
  endtask

  task automatic doPush(input logic [31:0] v);
    refSp = refSp - 4;
    refMem[refSp[11:2]] = v;
    runCmd(3'd0, v, 32'hDEAD_0000);
    checkRegs("R2 R12 push");
    check("R2 pushed word", mem[refSp[11:2]], v);
    check("R2 word above kept", mem[refSp[11:2] + 10'd1], refMem[refSp[11:2] + 10'd1]);
  endtask

  task automatic doPop();
    logic [31:0] exp;
    exp = refMem[refSp[11:2]];
    refSp = refSp + 4;
    runCmd(3'd1, 32'h0, 32'h0);
    checkRegs("R3 R12 pop");
    check("R3 pop data", popData, exp);
  endtask

  task automatic doCall(input logic [31:0] target, input logic [31:0] ra);
    refSp = refSp - 4;
    refMem[refSp[11:2]] = ra;
    refIp = target;
    runCmd(3'd2, target, ra);
    checkRegs("R4 R12 call");
    check("R4 return addr stored", mem[refSp[11:2]], ra);
  endtask

  task automatic doRet();
    refIp = refMem[refSp[11:2]];
    refSp = refSp + 4;
    runCmd(3'd3, 32'h5555_5555, 32'h0);
    checkRegs("R5 R12 ret");
  endtask

  task automatic doEnter();
    refSp = refSp - 4;
    refMem[refSp[11:2]] = refFp;
    refFp = refSp;
    runCmd(3'd4, 32'h7777_0000, 32'h0);
    checkRegs("R6 R12 enter");
    check("R6 saved fp", mem[refSp[11:2]], refMem[refSp[11:2]]);
  endtask

  task automatic doLeave();
    refSp = refFp;
    refFp = refMem[refSp[11:2]];
    refSp = refSp + 4;
    runCmd(3'd5, 32'h0, 32'h0);
    checkRegs("R7 R12 leave");
  endtask

  task automatic doUnused(input logic [2:0] op);
    runCmd(op, 32'h1234_5678, 32'h8765_4321);
    checkRegs("R11 unused code");
    check("R11 memory kept", mem[refSp[11:2] - 10'd1], refMem[refSp[11:2] - 10'd1]);
  endtask

  task automatic doIgnoreWhileBusy();
    int waitCnt;
    memLat = 3;
    refSp = refSp - 4;
    refMem[refSp[11:2]] = 32'hBEEF_0001;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd0; cmdArg = 32'hBEEF_0001; retAddr = 32'h0;
    @(negedge clk);
    cmdOp = 3'd2; cmdArg = 32'h0000_9999; retAddr = 32'h0000_4444;
    @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    @(negedge clk);
    @(negedge clk);
    checkRegs("R10 second command ignored");
    check("R10 top word", mem[refSp[11:2]], 32'hBEEF_0001);
    check("R10 still idle", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    refSp = SP0; refFp = FP0; refIp = IP0;
    repeat (3) @(negedge clk);
    check("R1 busy low", {31'b0, busy}, 32'd0);
    check("R1 done low", {31'b0, done}, 32'd0);
    check("R1 memReq low", {31'b0, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R1 reset values");

    memLat = 0;
    doPush(32'h1111_0001);
    doPush(32'h2222_0002);
    memLat = 2;
    doPop();
    doCall(32'h0000_2000, 32'h0000_1004);
    memLat = 1;
    doEnter();
    doPush(32'h3333_0003);
    doPush(32'h4444_0004);
    memLat = 4;
    doLeave();
    doRet();
    doPop();
    memLat = 0;
    doEnter();
    doLeave();
    doUnused(3'd6);
    doUnused(3'd7);
    doIgnoreWhileBusy();
    memLat = 3;
    doPop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule